// File: doc/BRIEF.md
# SCSI Command and Interrupt Register Unit

This unit holds the byte-wide register state that a host uses to steer a small SCSI protocol controller: the command byte, the status byte, the interrupt-cause byte, the sequence-step byte, the FIFO-flags byte, the three configuration bytes and the transfer counter. The host reaches it through a synchronous byte port with address, write strobe, write data, read strobe and read data. Every side effect of an access takes place at the clock edge that ends the cycle in which the strobe is high. Read data is combinational from the current register state, so a read returns the value the register held before that edge.

A byte written to the command address is decoded into a 7-bit operation code in bits 6:0 and a DMA flag in bit 7. The housekeeping operations (no-op, flush, chip reset, bus reset, message accept, pad, enable and disable selection, initiator-complete) change the status, interrupt and sequence registers directly. Selection and transfer operations only emit a one-cycle start pulse for the neighbouring protocol units. A single level interrupt line follows the interrupt bit of the status register. Reading the interrupt-cause register is destructive and also acknowledges the interrupt.

Top module: `scsi_cmd_regs`

## Requirements
- R1: Raising the interrupt sets status bit 7 and drives `irq` high; lowering clears both. `irq` always equals status bit 7, and a second raise while it is set changes nothing.
- R2: A read at the interrupt address (5) returns the old interrupt byte. At that edge the interrupt byte becomes 0, status bit 4 (TC) clears, the sequence byte becomes 4 and the interrupt is lowered.
- R3: A known command with bit 7 set enters DMA mode (`dma_mode`=1) and copies the written counter bytes into the readable counter at addresses 0..2. A known command with bit 7 clear leaves DMA mode and keeps the readable counter.
- R4: Flush (code 0x01) sets the interrupt byte to function-complete (0x08), zeroes the sequence and flags bytes, and leaves `irq` unchanged.
- R5: Bus reset (code 0x03) sets the interrupt byte to reset-detected (0x80). It raises the interrupt only when bit 6 of the last byte written to config 1 is clear.
- R6: Chip reset (code 0x02) and `rst_n` clear every register and the counter, set config 1 (address 8) to 0x07, clear DMA mode and drive `irq` low.
- R7: Message accept (code 0x12) sets the interrupt byte to disconnect (0x20), zeroes the sequence and flags bytes, and raises the interrupt.
- R8: Pad (code 0x18) sets status to TC (0x10) while keeping bit 7, sets the interrupt byte to 0x08 and zeroes the sequence byte.
- R9: Enable selection (0x44) clears the interrupt byte. Disable selection (0x45) clears it and raises the interrupt.
- R10: Initiator-complete (0x11) sets the flags byte to 2, sets the status phase field (bits 2:0) to message-in (7), sets the interrupt byte to 0x08 and raises the interrupt.
- R11: A write to a counter byte (addresses 0..2) clears TC and goes to the written copy only. The readable counter changes only through the reload of R3.
- R12: Writes to config 1..3 (addresses 8..10) read back. Writes at addresses 4, 5 and 6 load the bus-ID, sync-period and sync-offset bytes, which appear on their outputs and never on `rd_data`.
- R13: Select (0x41), select with attention (0x42), select with attention and stop (0x43) and transfer (0x10) pulse `sel_go[0]`, `sel_go[1]`, `sel_go[2]` and `xfer_go` for exactly one cycle after the write. At most one pulse is high at a time.
- R14: Unknown codes change nothing, including DMA mode and the command byte. A read strobe in the same cycle as a write has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (ignored while wr_en is high) |
| rd_data | output | 8 | Read data for addr |
| irq | output | 1 | Level interrupt |
| dma_mode | output | 1 | Last known command carried the DMA flag |
| bus_id_cfg | output | 8 | Bus-ID byte for the selection unit |
| sync_period | output | 8 | Sync period byte |
| sync_offset | output | 8 | Sync offset byte |
| sel_go | output | 3 | Selection start pulses |
| xfer_go | output | 1 | Transfer start pulse |

## Verification
On every cycle the assertions check that the line matches the interrupt bit, that the start pulses never overlap, and that an interrupt read leaves the cause byte zero with the line low. On each matching command they also check the outcomes of flush, message accept, chip reset, the masked bus reset, the DMA flag, the bus-ID load and an unknown code. Only the bench's scenarios can show the byte values that reads return. This includes the split between written and readable counter copies, config mirroring, the TC clears, pad keeping the interrupt bit, and reads that lose their side effect when a write shares the cycle.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

   localparam int REG_W = 8;

   typedef enum logic [3:0] {
      OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_ICCS, OP_MSGACC,
      OP_PAD, OP_SEL, OP_SELATN, OP_SELSTOP, OP_ENSEL, OP_DISSEL, OP_NONE
   } cmd_op_e;

   typedef struct packed {
      logic    known;
      logic    dma;
      cmd_op_e op;
   } cmd_act_t;

   // operation codes in bits 6:0 of the command byte, DMA flag in bit 7
   localparam int          DMA_FLAG_BIT = 7;
   localparam logic [6:0] CODE_NOP     = 7'h00;
   localparam logic [6:0] CODE_FLUSH   = 7'h01;
   localparam logic [6:0] CODE_CHIPRST = 7'h02;
   localparam logic [6:0] CODE_BUSRST  = 7'h03;
   localparam logic [6:0] CODE_XFER    = 7'h10;
   localparam logic [6:0] CODE_ICCS    = 7'h11;
   localparam logic [6:0] CODE_MSGACC  = 7'h12;
   localparam logic [6:0] CODE_PAD     = 7'h18;
   localparam logic [6:0] CODE_SEL     = 7'h41;
   localparam logic [6:0] CODE_SELATN  = 7'h42;
   localparam logic [6:0] CODE_SELSTOP = 7'h43;
   localparam logic [6:0] CODE_ENSEL   = 7'h44;
   localparam logic [6:0] CODE_DISSEL  = 7'h45;

   // status byte fields
   localparam int          ST_INT      = 7;
   localparam int          ST_TC       = 4;
   localparam logic [2:0] PH_MSG_IN   = 3'b111;

   // interrupt-cause codes
   localparam logic [REG_W-1:0] IC_FUNC_DONE = 8'h08;
   localparam logic [REG_W-1:0] IC_DISCONN   = 8'h20;
   localparam logic [REG_W-1:0] IC_BUS_RESET = 8'h80;

   localparam logic [REG_W-1:0] FLAGS_STATUS_PAIR = 8'h02;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_ctl_pkg::*;
(
   input  logic [REG_W-1:0] cmd_byte,
   output cmd_act_t         act
);

   logic [6:0] code;
   assign code = cmd_byte[6:0];

   always_comb begin
      act.dma   = cmd_byte[DMA_FLAG_BIT];
      act.known = 1'b1;
      case (code)
         CODE_NOP:     act.op = OP_NOP;
         CODE_FLUSH:   act.op = OP_FLUSH;
         CODE_CHIPRST: act.op = OP_CHIPRST;
         CODE_BUSRST:  act.op = OP_BUSRST;
         CODE_XFER:    act.op = OP_XFER;
         CODE_ICCS:    act.op = OP_ICCS;
         CODE_MSGACC:  act.op = OP_MSGACC;
         CODE_PAD:     act.op = OP_PAD;
         CODE_SEL:     act.op = OP_SEL;
         CODE_SELATN:  act.op = OP_SELATN;
         CODE_SELSTOP: act.op = OP_SELSTOP;
         CODE_ENSEL:   act.op = OP_ENSEL;
         CODE_DISSEL:  act.op = OP_DISSEL;
         default: begin
            act.op    = OP_NONE;
            act.known = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/scsi_xfer_count.sv
module scsi_xfer_count #(
   parameter int BYTES = 3,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic [BYTES-1:0]           wr_sel,
   input  logic [W-1:0]               wdata,
   input  logic                       reload,
   output logic [BYTES-1:0][W-1:0]    rd_val
);

   for (genvar g = 0; g < BYTES; g++) begin : g_byte
      logic [W-1:0] staged_q;
      logic [W-1:0] live_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            staged_q <= '0;
            live_q   <= '0;
         end else if (clear) begin
            staged_q <= '0;
            live_q   <= '0;
         end else begin
            if (wr_sel[g]) staged_q <= wdata;
            if (reload)    live_q   <= staged_q;
         end
      end

      assign rd_val[g] = live_q;
   end

endmodule

// File: rtl/scsi_irq_line.sv
module scsi_irq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic raise,
   input  logic lower,
   output logic irq
);

   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              line_q <= 1'b0;
      else if (clear || lower) line_q <= 1'b0;
      else if (raise)          line_q <= 1'b1;
   end

   assign irq = line_q;

endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
   import scsi_ctl_pkg::*;
#(
   parameter int               ADDR_W      = 4,
   parameter int               CNT_BYTES   = 3,
   parameter int               CFG_REGS    = 3,
   parameter logic [REG_W-1:0] CFG1_INIT   = 8'h07,
   parameter logic [REG_W-1:0] SEQ_DONE    = 8'h04,
   parameter int               RPT_OFF_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq,
   output logic              dma_mode,
   output logic [REG_W-1:0]  bus_id_cfg,
   output logic [REG_W-1:0]  sync_period,
   output logic [REG_W-1:0]  sync_offset,
   output logic [2:0]        sel_go,
   output logic              xfer_go
);

   localparam int TOP_ADDR = CNT_BYTES + 5 + CFG_REGS;
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(CNT_BYTES);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(CNT_BYTES + 1);
   localparam logic [ADDR_W-1:0] A_INTR  = ADDR_W'(CNT_BYTES + 2);
   localparam logic [ADDR_W-1:0] A_SEQ   = ADDR_W'(CNT_BYTES + 3);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(CNT_BYTES + 4);
   localparam int                CFG_BASE = CNT_BYTES + 5;
   // write-side aliases of the status, interrupt and sequence addresses
   localparam logic [ADDR_W-1:0] A_BUSID = A_STAT;
   localparam logic [ADDR_W-1:0] A_SYNCP = A_INTR;
   localparam logic [ADDR_W-1:0] A_SYNCO = A_SEQ;

   if (CNT_BYTES < 1 || CNT_BYTES > 4) begin : g_bad_cnt
      $error("CNT_BYTES must be 1..4");
   end
   if (CFG_REGS < 1 || CFG_REGS > 4) begin : g_bad_cfg
      $error("CFG_REGS must be 1..4");
   end
   if (TOP_ADDR > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (RPT_OFF_BIT < 0 || RPT_OFF_BIT >= REG_W) begin : g_bad_bit
      $error("RPT_OFF_BIT outside the config byte");
   end

   // ---------------- access decode ----------------
   cmd_act_t act;
   logic     wr_cmd, go, soft_rst, rd_intr, reload;
   logic [CNT_BYTES-1:0] cnt_wr;

   scsi_cmd_decode u_dec (.cmd_byte(wr_data), .act(act));

   assign wr_cmd   = wr_en && (addr == A_CMD);
   assign go       = wr_cmd && act.known;
   assign soft_rst = go && (act.op == OP_CHIPRST);
   assign rd_intr  = rd_en && !wr_en && (addr == A_INTR);
   assign reload   = go && act.dma && !soft_rst;

   for (genvar c = 0; c < CNT_BYTES; c++) begin : g_cnt_sel
      assign cnt_wr[c] = wr_en && (addr == ADDR_W'(c));
   end

   // ---------------- transfer counter ----------------
   logic [CNT_BYTES-1:0][REG_W-1:0] cnt_rd;

   scsi_xfer_count #(.BYTES(CNT_BYTES), .W(REG_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(soft_rst), .wr_sel(cnt_wr),
      .wdata(wr_data), .reload(reload), .rd_val(cnt_rd)
   );

   // ---------------- register state ----------------
   logic [REG_W-1:0] stat_q, intr_q, seq_q, flags_q, cmd_q;
   logic [REG_W-1:0] stat_n, intr_n, seq_n, flags_n;
   logic [REG_W-1:0] busid_q, syncp_q, synco_q;
   logic             dma_q, rpt_off_q;
   logic [2:0]       sel_go_q;
   logic             xfer_go_q;
   logic             raise, lower;
   logic [CFG_REGS-1:0][REG_W-1:0] cfg_q;

   always_comb begin
      stat_n  = stat_q;
      intr_n  = intr_q;
      seq_n   = seq_q;
      flags_n = flags_q;
      raise   = 1'b0;
      lower   = 1'b0;
      if (|cnt_wr) stat_n[ST_TC] = 1'b0;
      if (rd_intr) begin
         intr_n        = '0;
         stat_n[ST_TC] = 1'b0;
         seq_n         = SEQ_DONE;
         lower         = 1'b1;
      end
      if (go) begin
         case (act.op)
            OP_FLUSH: begin
               intr_n  = IC_FUNC_DONE;
               seq_n   = '0;
               flags_n = '0;
            end
            OP_BUSRST: begin
               intr_n = IC_BUS_RESET;
               raise  = !rpt_off_q;
            end
            OP_ICCS: begin
               flags_n     = FLAGS_STATUS_PAIR;
               stat_n[2:0] = PH_MSG_IN;
               intr_n      = IC_FUNC_DONE;
               raise       = 1'b1;
            end
            OP_MSGACC: begin
               intr_n  = IC_DISCONN;
               seq_n   = '0;
               flags_n = '0;
               raise   = 1'b1;
            end
            OP_PAD: begin
               stat_n         = '0;
               stat_n[ST_INT] = stat_q[ST_INT];
               stat_n[ST_TC]  = 1'b1;
               intr_n         = IC_FUNC_DONE;
               seq_n          = '0;
            end
            OP_ENSEL:  intr_n = '0;
            OP_DISSEL: begin
               intr_n = '0;
               raise  = 1'b1;
            end
            default: ;
         endcase
      end
      if (raise) stat_n[ST_INT] = 1'b1;
      if (lower) stat_n[ST_INT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0; intr_q <= '0; seq_q <= '0; flags_q <= '0; cmd_q <= '0;
         busid_q <= '0; syncp_q <= '0; synco_q <= '0;
         dma_q <= 1'b0; rpt_off_q <= 1'b0; sel_go_q <= '0; xfer_go_q <= 1'b0;
      end else if (soft_rst) begin
         stat_q <= '0; intr_q <= '0; seq_q <= '0; flags_q <= '0; cmd_q <= '0;
         busid_q <= '0; syncp_q <= '0; synco_q <= '0;
         dma_q <= 1'b0; rpt_off_q <= 1'b0; sel_go_q <= '0; xfer_go_q <= 1'b0;
      end else begin
         stat_q  <= stat_n;
         intr_q  <= intr_n;
         seq_q   <= seq_n;
         flags_q <= flags_n;
         if (go) begin
            cmd_q <= wr_data;
            dma_q <= act.dma;
         end
         if (wr_en && addr == A_BUSID) busid_q <= wr_data;
         if (wr_en && addr == A_SYNCP) syncp_q <= wr_data;
         if (wr_en && addr == A_SYNCO) synco_q <= wr_data;
         if (wr_en && addr == ADDR_W'(CFG_BASE)) rpt_off_q <= wr_data[RPT_OFF_BIT];
         sel_go_q  <= {go && act.op == OP_SELSTOP, go && act.op == OP_SELATN,
                       go && act.op == OP_SEL};
         xfer_go_q <= go && act.op == OP_XFER;
      end
   end

   for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
      localparam logic [REG_W-1:0] INIT = (k == 0) ? CFG1_INIT : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cfg_q[k] <= INIT;
         else if (soft_rst) cfg_q[k] <= INIT;
         else if (wr_en && addr == ADDR_W'(CFG_BASE + k)) cfg_q[k] <= wr_data;
      end
   end

   scsi_irq_line u_irq (
      .clk(clk), .rst_n(rst_n), .clear(soft_rst),
      .raise(raise), .lower(lower), .irq(irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < CNT_BYTES; i++)
         if (addr == ADDR_W'(i)) rd_data = cnt_rd[i];
      for (int i = 0; i < CFG_REGS; i++)
         if (addr == ADDR_W'(CFG_BASE + i)) rd_data = cfg_q[i];
      if (addr == A_CMD)   rd_data = cmd_q;
      if (addr == A_STAT)  rd_data = stat_q;
      if (addr == A_INTR)  rd_data = intr_q;
      if (addr == A_SEQ)   rd_data = seq_q;
      if (addr == A_FLAGS) rd_data = flags_q;
   end

   assign dma_mode    = dma_q;
   assign bus_id_cfg  = busid_q;
   assign sync_period = syncp_q;
   assign sync_offset = synco_q;
   assign sel_go      = sel_go_q;
   assign xfer_go     = xfer_go_q;

   // ---------------- assertions ----------------
   assert_irq_follows_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq == stat_q[ST_INT]);

   assert_intr_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_intr |=> (intr_q == '0) && (seq_q == SEQ_DONE) && !irq);

   assert_dma_flag_sets_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && act.dma && !soft_rst) |=> dma_mode);

   assert_flush_keeps_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && act.op == OP_FLUSH) |=> (irq == $past(irq)) && (intr_q == IC_FUNC_DONE));

   assert_masked_bus_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && act.op == OP_BUSRST && rpt_off_q) |=> (irq == $past(irq)));

   assert_chip_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cfg_q[0] == CFG1_INIT) && !dma_mode && !irq && (stat_q == '0));

   assert_msg_accept_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && act.op == OP_MSGACC) |=> irq && (intr_q == IC_DISCONN));

   assert_busid_loads_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_BUSID) |=> bus_id_cfg == $past(wr_data));

   assert_one_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_go, xfer_go}));

   assert_unknown_no_change_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !act.known) |=> $stable(stat_q) && $stable(intr_q) && $stable(dma_q)
                                 && $stable(cmd_q) && $stable(irq));

endmodule

// File: tb/scsi_cmd_regs_test.sv
module scsi_cmd_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq, dma_mode, xfer_go;
   logic [7:0] bus_id_cfg, sync_period, sync_offset;
   logic [2:0] sel_go;

   always #10 clk = ~clk;   // 50 MHz

   scsi_cmd_regs uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .dma_mode(dma_mode),
      .bus_id_cfg(bus_id_cfg), .sync_period(sync_period), .sync_offset(sync_offset),
      .sel_go(sel_go), .xfer_go(xfer_go)
   );

   int checks = 0;
   int errors = 0;

   // ------------- behavioural reference model -------------
   int m_cw[3], m_cr[3], m_cfg[3];
   int m_cmd, m_stat, m_intr, m_seq, m_flags, m_bus, m_sp, m_so;
   int m_rptoff, m_dma, m_irq, m_sel, m_xfer;
   int last_rd;

   task automatic m_reset();
      for (int i = 0; i < 3; i++) begin m_cw[i] = 0; m_cr[i] = 0; m_cfg[i] = 0; end
      m_cfg[0] = 7;
      m_cmd = 0; m_stat = 0; m_intr = 0; m_seq = 0; m_flags = 0;
      m_bus = 0; m_sp = 0; m_so = 0; m_rptoff = 0; m_dma = 0; m_irq = 0;
      m_sel = 0; m_xfer = 0;
   endtask

   task automatic m_raise();
      m_stat = m_stat | 'h80; m_irq = 1;
   endtask

   function automatic int m_read(int a);
      case (a)
         0, 1, 2: return m_cr[a];
         3: return m_cmd;
         4: return m_stat;
         5: return m_intr;
         6: return m_seq;
         7: return m_flags;
         8, 9, 10: return m_cfg[a-8];
         default: return 0;
      endcase
   endfunction

   task automatic m_command(int d);
      int code;
      code = d & 'h7f;
      if (!(code inside {'h00, 'h01, 'h02, 'h03, 'h10, 'h11, 'h12, 'h18,
                         'h41, 'h42, 'h43, 'h44, 'h45})) return;
      if (code == 'h02) begin m_reset(); return; end
      m_cmd = d;
      m_dma = (d >> 7) & 1;
      if (m_dma != 0) for (int i = 0; i < 3; i++) m_cr[i] = m_cw[i];
      case (code)
         'h01: begin m_intr = 'h08; m_seq = 0; m_flags = 0; end
         'h03: begin m_intr = 'h80; if (m_rptoff == 0) m_raise(); end
         'h10: m_xfer = 1;
         'h11: begin m_flags = 2; m_stat = (m_stat & 'hf8) | 7; m_intr = 'h08; m_raise(); end
         'h12: begin m_intr = 'h20; m_seq = 0; m_flags = 0; m_raise(); end
         'h18: begin m_stat = (m_stat & 'h80) | 'h10; m_intr = 'h08; m_seq = 0; end
         'h41: m_sel = 1;
         'h42: m_sel = 2;
         'h43: m_sel = 4;
         'h44: m_intr = 0;
         'h45: begin m_intr = 0; m_raise(); end
         default: ;
      endcase
   endtask

   task automatic m_step(bit w, bit r, int a, int d);
      m_sel = 0; m_xfer = 0;
      if (w) begin
         case (a)
            0, 1, 2: begin m_cw[a] = d; m_stat = m_stat & ~'h10; end
            3: m_command(d);
            4: m_bus = d;
            5: m_sp = d;
            6: m_so = d;
            8: begin m_cfg[0] = d; m_rptoff = (d >> 6) & 1; end
            9, 10: m_cfg[a-8] = d;
            default: ;
         endcase
      end else if (r && a == 5) begin
         m_intr = 0; m_stat = m_stat & ~'h10 & ~'h80; m_seq = 4; m_irq = 0;
      end
   endtask

   // ------------- checking -------------
   task automatic chk(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(int'(irq), m_irq, "R1 irq line");
      chk(int'(dma_mode), m_dma, "R3 dma mode");
      chk(int'(sel_go), m_sel, "R13 sel pulses");
      chk(int'(xfer_go), m_xfer, "R13 xfer pulse");
      chk(int'(bus_id_cfg), m_bus, "R12 bus id");
      chk(int'(sync_period), m_sp, "R12 sync period");
      chk(int'(sync_offset), m_so, "R12 sync offset");
   endtask

   task automatic cyc(bit w, bit r, int a, int d, string tag);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = 4'(a); wr_data = 8'(d);
      #1;
      last_rd = int'(rd_data);
      if (r) chk(last_rd, m_read(a), tag);
      @(posedge clk);
      #1;
      m_step(w, r, a, d);
      compare_all();
   endtask

   task automatic wr(int a, int d, string tag);  cyc(1, 0, a, d, tag); endtask
   task automatic rd(int a, string tag);         cyc(0, 1, a, 0, tag); endtask
   task automatic idle();                        cyc(0, 0, 0, 0, "idle"); endtask
   task automatic rd_lit(int a, int lit, string tag);
      rd(a, tag);
      chk(last_rd, lit, tag);
   endtask

   // ------------- watchdog -------------
   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ------------- scenarios -------------
   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      #1;
      compare_all();                                     // R6 reset outputs
      @(negedge clk); rst_n = 1'b1;
      idle();

      // R6 reset values
      rd_lit(8, 'h07, "R6 cfg1 init");
      rd_lit(4, 'h00, "R6 status zero");
      rd_lit(3, 'h00, "R6 command zero");

      // R11 counter writes stay hidden, R3 reload with DMA flag
      wr(0, 'h34, "R11"); wr(1, 'h12, "R11"); wr(2, 'h05, "R11");
      rd_lit(0, 'h00, "R11 hidden lo");
      wr(3, 'h80, "R3 dma nop");
      rd_lit(0, 'h34, "R3 reload lo");
      rd_lit(2, 'h05, "R3 reload hi");
      wr(0, 'h99, "R11");
      wr(3, 'h00, "R3 plain nop");
      rd_lit(0, 'h34, "R3 kept lo");

      // R8 pad, R11 count write clears TC
      wr(3, 'h18, "R8 pad");
      rd_lit(4, 'h10, "R8 status TC");
      rd(6, "R8 seq");
      wr(1, 'h00, "R11 tc clear");
      rd_lit(4, 'h00, "R11 status after count write");

      // R2 destructive read after pad
      wr(3, 'h18, "R8 pad");
      rd_lit(5, 'h08, "R2 old intr");
      rd_lit(5, 'h00, "R2 intr cleared");
      rd_lit(6, 'h04, "R2 seq done");
      rd_lit(4, 'h00, "R2 TC cleared");

      // R7 message accept, R1 double raise
      wr(3, 'h12, "R7 msg accept");
      rd_lit(5 - 1, 'h80, "R7 status int");
      wr(3, 'h12, "R1 raise again");
      rd_lit(5, 'h20, "R7 disconnect code");
      idle();

      // R5 bus reset unmasked then masked
      wr(3, 'h03, "R5 bus reset");
      rd_lit(5, 'h80, "R5 reset code");
      wr(8, 'h47, "R12 cfg1");
      rd_lit(8, 'h47, "R12 cfg1 mirror");
      wr(3, 'h03, "R5 masked bus reset");
      rd_lit(4, 'h00, "R5 no int when masked");
      rd_lit(5, 'h80, "R5 masked code");

      // R9 disable selection raises, R4 flush keeps line
      wr(3, 'h45, "R9 disable sel");
      wr(3, 'h01, "R4 flush");
      rd_lit(7, 'h00, "R4 flags");
      rd_lit(6, 'h00, "R4 seq");
      rd_lit(5, 'h08, "R4 func done");
      wr(3, 'h12, "R7");
      wr(3, 'h44, "R9 enable sel");
      rd_lit(5, 'h00, "R9 intr cleared");

      // R10 initiator complete
      wr(3, 'h11, "R10 iccs");
      rd_lit(7, 'h02, "R10 flags");
      rd_lit(4, 'h87, "R10 status");
      rd_lit(5, 'h08, "R10 intr");

      // R13 start pulses, R3 flag on a selection
      wr(3, 'h41, "R13 sel");
      wr(3, 'hC2, "R13 sel atn dma");
      wr(3, 'h43, "R13 sel stop");
      wr(3, 'h10, "R13 xfer");
      idle();

      // R12 write-only registers
      wr(4, 'h05, "R12 bus id");
      wr(6, 'h0F, "R12 sync offset");
      wr(9, 'hA5, "R12 cfg2");
      wr(10, 'h5A, "R12 cfg3");
      rd_lit(9, 'hA5, "R12 cfg2 mirror");
      rd_lit(10, 'h5A, "R12 cfg3 mirror");
      rd_lit(4, 'h07, "R12 status not bus id");
      rd_lit(6, 'h04, "R12 seq not sync offset");

      // R14 unknown codes and read during write
      wr(3, 'h12, "R7");
      wr(3, 'h7F, "R14 unknown");
      wr(3, 'h9A, "R14 unknown dma");
      rd_lit(3, 'h12, "R14 cmd kept");
      cyc(1, 1, 5, 'h33, "R14 read with write");
      rd_lit(5, 'h20, "R14 intr kept");
      wr(3, 'h80, "R3");

      // R6 chip reset
      wr(3, 'h12, "R7");
      wr(3, 'h82, "R6 chip reset");
      rd_lit(8, 'h07, "R6 cfg1 after reset");
      rd_lit(0, 'h00, "R6 counter after reset");
      rd_lit(9, 'h00, "R6 cfg2 after reset");
      wr(3, 'h03, "R5 reset clears mask");
      rd_lit(4, 'h80, "R5 unmasked after reset");
      idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule